// File: doc/BRIEF.md
# Banked Transpose Buffer for a Two-Pass Block Transform

This block sits between the vertical (first) pass and the horizontal (second) pass of a separable two-dimensional block transform. The first pass delivers one complete column of 16-bit coefficients per clock. Once a whole block has arrived, the buffer hands back one complete row per clock, so the second pass receives the block transposed.

Storage is split into independent banks. Each bank is a synchronous RAM with one write port and one read port, one word wide. Element (row r, column c) of an N×N block is stored in bank (r + c) mod N at address c. This skew places the N elements of any column in N different banks, and it does the same for the N elements of any row. A column write therefore completes in a single cycle, and so does a row read, with no bank conflict. On each side a lane rotator turns the element order into the bank order and back.

Block size N is 4, 8, 16 or 32. Only the first N banks are active; the others stay idle. A two-state controller sequences the work:
- **FILL** takes in N columns. The transition *block_written*, on the N-th accepted column, moves it to DRAIN.
- **DRAIN** issues N row reads. The transition *block_read*, on the N-th issued row, returns it to FILL.

Top module: `xpose_bank_buf`

## Requirements
- R1: During and straight after reset the buffer is empty: `col_ready`=1, `full`=0, `row_valid`=0.
- R2: `size_sel` encodes the block size as 0→4, 1→8, 2→16, 3→32. `full` stays low until the N-th column of the block has been accepted.
- R3: A column is accepted on a clock edge where `col_valid` and `col_ready` are both high. Element r of the column sits at bits [16r+15:16r]. Lanes r ≥ N are ignored.
- R4: `full` rises and `col_ready` falls in the cycle after the N-th column is accepted. A column offered while `full` is high is dropped and leaves the stored block unchanged.
- R5: While `full` is high, each edge with `row_ready` high issues the next row, in order from row 0 to row N-1. `row_valid` is high in the cycle after the edge that issued the row. Lane c of `row_data` then holds element r of the column c that was written, and lanes c ≥ N read 0.
- R6: An edge where `full` is high and `row_ready` is low issues no row, and `row_valid` is low in the following cycle.
- R7: In the cycle after the N-th row is issued, `full` is low and `col_ready` is high, so the next block can start at once.
- R8: The block size is sampled with the first column of a block. Changes to `size_sel` later in that block, or while the block drains, have no effect on that block.
- R9: With `row_ready` held high, N rows come out on N consecutive cycles, one full row per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_sel | input | 2 | Block size code, sampled with the first column |
| col_valid | input | 1 | A column is offered |
| col_data | input | MAXN*DW | Column elements, lane r = row r |
| col_ready | output | 1 | Buffer accepts columns (FILL state) |
| full | output | 1 | A complete block is stored (DRAIN state) |
| row_ready | input | 1 | Consumer takes a row this cycle |
| row_valid | output | 1 | `row_data` carries a row |
| row_data | output | MAXN*DW | Row elements, lane c = column c |

## Verification
The bench builds the block with its default parameters: 32 banks and 16-bit elements. This makes every size code reachable, including the largest skew, where the rotation amount spans all five index bits. Blocks of each size are drained both back-to-back and with random consumer stalls. Spare lanes carry random data to show that they are ignored, and a stray column is offered while the block is held. Mid-block size changes toward a larger block test that the sampled size holds until the buffer is empty again.

// File: rtl/xpb_pkg.sv
package xpb_pkg;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } xpb_state_e;

    // Number of lanes in use for a size code: 4, 8, 16, 32
    function automatic int lanes_for(input logic [1:0] code);
        return 4 << code;
    endfunction

endpackage

// File: rtl/xpb_bank.sv
module xpb_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/xpb_rotator.sv
module xpb_rotator #(
    parameter int DW    = 16,
    parameter int LANES = 32,
    localparam int IW   = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] din,
    input  logic [IW-1:0]       amt,
    input  logic [IW-1:0]       mask,
    output logic [LANES*DW-1:0] dout
);

    // Lane i takes input lane (i - amt) mod (mask+1); lanes above mask are zero
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IW-1:0] src;
        always_comb begin
            src = (IW'(i) - amt) & mask;
            if (IW'(i) <= mask) begin
                dout[i*DW +: DW] = din[src*DW +: DW];
            end else begin
                dout[i*DW +: DW] = '0;
            end
        end
    end

endmodule

// File: rtl/xpb_ctrl.sv
module xpb_ctrl
    import xpb_pkg::*;
#(
    parameter int MAXN = 32,
    localparam int IW  = $clog2(MAXN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    size_sel,
    input  logic          col_valid,
    input  logic          row_ready,
    output logic          col_ready,
    output logic          full,
    output logic          wr_en,
    output logic          rd_en,
    output logic [IW-1:0] col_idx,
    output logic [IW-1:0] row_idx,
    output logic [IW-1:0] mask,
    output logic [IW-1:0] out_row,
    output logic [IW-1:0] out_mask,
    output logic          out_valid
);

    xpb_state_e    state_q, state_d;
    logic [IW-1:0] col_cnt_q, row_cnt_q, mask_q;
    logic [IW-1:0] mask_dec;
    logic          last_col, last_row;

    always_comb begin
        if (lanes_for(size_sel) > MAXN) begin
            mask_dec = IW'(MAXN - 1);
        end else begin
            mask_dec = IW'(lanes_for(size_sel) - 1);
        end
    end

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_FILL;
            col_cnt_q <= '0;
            row_cnt_q <= '0;
            mask_q    <= '0;
            out_row   <= '0;
            out_mask  <= '0;
            out_valid <= 1'b0;
        end else begin
            state_q   <= state_d;
            out_valid <= rd_en;
            if (wr_en) begin
                col_cnt_q <= last_col ? '0 : col_cnt_q + 1'b1;
                if (col_cnt_q == '0) begin
                    mask_q <= mask_dec;
                end
            end
            if (rd_en) begin
                row_cnt_q <= last_row ? '0 : row_cnt_q + 1'b1;
                out_row   <= row_cnt_q;
                out_mask  <= mask_q;
            end
        end
    end

    // Outputs and next state
    always_comb begin
        state_d   = state_q;
        col_ready = 1'b0;
        full      = 1'b0;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        mask      = mask_q;
        last_col  = 1'b0;
        last_row  = 1'b0;
        col_idx   = col_cnt_q;
        row_idx   = row_cnt_q;
        unique case (state_q)
            ST_FILL: begin
                col_ready = 1'b1;
                wr_en     = col_valid;
                if (col_cnt_q == '0) begin
                    mask = mask_dec;
                end
                last_col = (col_cnt_q == mask);
                if (wr_en && last_col) begin
                    state_d = ST_DRAIN;   // block_written
                end
            end
            ST_DRAIN: begin
                full     = 1'b1;
                rd_en    = row_ready;
                last_row = (row_cnt_q == mask_q);
                if (rd_en && last_row) begin
                    state_d = ST_FILL;    // block_read
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    assert_full_after_last_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && col_cnt_q == mask) |=> (full && !col_ready));

    assert_empty_after_last_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && row_cnt_q == mask_q) |=> (!full && col_ready));

    assert_size_held_in_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && $past(full)) |-> $stable(mask_q));

    assert_row_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (row_cnt_q <= mask_q));

endmodule

// File: rtl/xpose_bank_buf.sv
module xpose_bank_buf #(
    parameter int DW   = 16,
    parameter int MAXN = 32,
    localparam int IW  = $clog2(MAXN),
    localparam int VW  = MAXN * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    size_sel,
    input  logic          col_valid,
    input  logic [VW-1:0] col_data,
    output logic          col_ready,
    output logic          full,
    input  logic          row_ready,
    output logic          row_valid,
    output logic [VW-1:0] row_data
);

    logic          wr_en, rd_en, out_valid;
    logic [IW-1:0] col_idx, row_idx, mask, out_row, out_mask, out_amt;
    logic [VW-1:0] bank_wdata, bank_rdata;

    xpb_ctrl #(.MAXN(MAXN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_sel  (size_sel),
        .col_valid (col_valid),
        .row_ready (row_ready),
        .col_ready (col_ready),
        .full      (full),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .col_idx   (col_idx),
        .row_idx   (row_idx),
        .mask      (mask),
        .out_row   (out_row),
        .out_mask  (out_mask),
        .out_valid (out_valid)
    );

    // Element r of column c goes to bank (r + c) mod N
    xpb_rotator #(.DW(DW), .LANES(MAXN)) u_wr_rot (
        .din  (col_data),
        .amt  (col_idx),
        .mask (mask),
        .dout (bank_wdata)
    );

    for (genvar b = 0; b < MAXN; b++) begin : g_bank
        logic          b_on;
        logic [IW-1:0] b_raddr;
        assign b_on    = (IW'(b) <= mask);
        assign b_raddr = (IW'(b) - row_idx) & mask;

        xpb_bank #(.DW(DW), .DEPTH(MAXN)) u_bank (
            .clk   (clk),
            .we    (wr_en && b_on),
            .waddr (col_idx),
            .wdata (bank_wdata[b*DW +: DW]),
            .re    (rd_en && b_on),
            .raddr (b_raddr),
            .rdata (bank_rdata[b*DW +: DW])
        );
    end

    // Lane c of row r comes from bank (r + c) mod N
    assign out_amt = (IW'(0) - out_row) & out_mask;

    xpb_rotator #(.DW(DW), .LANES(MAXN)) u_rd_rot (
        .din  (bank_rdata),
        .amt  (out_amt),
        .mask (out_mask),
        .dout (row_data)
    );

    assign row_valid = out_valid;

    assert_row_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> $past(full));

    assert_stall_gives_no_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !row_ready) |=> !row_valid);

    assert_no_write_while_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && col_valid) |=> (full || $past(row_ready)));

endmodule

// File: tb/xpose_bank_buf_bench.sv
module xpose_bank_buf_bench;

    localparam int DW   = 16;
    localparam int MAXN = 32;
    localparam int VW   = MAXN * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    size_sel = '0;
    logic          col_valid = 1'b0;
    logic [VW-1:0] col_data = '0;
    logic          col_ready, full;
    logic          row_ready = 1'b0;
    logic          row_valid;
    logic [VW-1:0] row_data;

    int            n_chk = 0;
    int            n_bad = 0;
    logic [VW-1:0] exp_q [$];

    always #5 clk = ~clk;

    xpose_bank_buf #(.DW(DW), .MAXN(MAXN)) u_xpose_bank_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_sel  (size_sel),
        .col_valid (col_valid),
        .col_data  (col_data),
        .col_ready (col_ready),
        .full      (full),
        .row_ready (row_ready),
        .row_valid (row_valid),
        .row_data  (row_data)
    );

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each produced row with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && row_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R5 unexpected row actual=%h expected=none", row_data);
            end else begin
                check("R5 row data", row_data, exp_q.pop_front());
            end
        end
    end

    // Driver: write one block of n columns; later columns present late_sel
    task automatic fill(input int n, input logic [1:0] sel, input logic [1:0] late_sel);
        logic [DW-1:0] m [MAXN][MAXN];
        for (int c = 0; c < n; c++) begin
            logic [VW-1:0] v;
            for (int r = 0; r < MAXN; r++) begin
                v[r*DW +: DW] = DW'($urandom);
                m[r][c] = v[r*DW +: DW];
            end
            size_sel  = (c == 0) ? sel : late_sel;
            col_valid = 1'b1;
            col_data  = v;
            if (c == 0) check("R3 col_ready at block start", VW'(col_ready), VW'(1));
            if (c == n - 1) check("R2 not full before last column", VW'(full), VW'(0));
            @(posedge clk);
            #1;
        end
        col_valid = 1'b0;
        for (int r = 0; r < n; r++) begin
            logic [VW-1:0] row;
            row = '0;
            for (int c = 0; c < n; c++) row[c*DW +: DW] = m[r][c];
            exp_q.push_back(row);
        end
        check("R4 full after last column", VW'(full), VW'(1));
        check("R4 col_ready low when full", VW'(col_ready), VW'(0));
        // stray column while full must be dropped
        col_valid = 1'b1;
        col_data  = {MAXN{16'hDEAD}};
        @(posedge clk);
        #1;
        col_valid = 1'b0;
        check("R4 still full after stray column", VW'(full), VW'(1));
    endtask

    task automatic drain(input int n, input bit stall);
        int issued = 0;
        while (issued < n) begin
            bit will;
            row_ready = stall ? 1'($urandom % 2) : 1'b1;
            #1;
            will = full && row_ready;
            @(posedge clk);
            @(negedge clk);
            if (stall)
                check(will ? "R5 row after request" : "R6 no row on stall",
                      VW'(row_valid), VW'(will));
            else
                check("R9 row every cycle", VW'(row_valid), VW'(1));
            if (will) issued++;
        end
        row_ready = 1'b0;
        check("R7 empty after last row", VW'(full), VW'(0));
        check("R7 col_ready after last row", VW'(col_ready), VW'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset col_ready", VW'(col_ready), VW'(1));
        check("R1 reset full", VW'(full), VW'(0));
        check("R1 reset row_valid", VW'(row_valid), VW'(0));
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 empty after reset", VW'(full), VW'(0));

        fill(4, 2'd0, 2'd0);   drain(4, 1'b0);
        fill(8, 2'd1, 2'd1);   drain(8, 1'b1);
        fill(16, 2'd2, 2'd2);  drain(16, 1'b0);
        fill(32, 2'd3, 2'd3);  drain(32, 1'b1);
        // R8: size changes after the first column are ignored
        fill(8, 2'd1, 2'd3);   drain(8, 1'b0);
        fill(4, 2'd0, 2'd2);   drain(4, 1'b1);
        fill(16, 2'd2, 2'd3);  drain(16, 1'b0);

        repeat (3) @(posedge clk);
        #1;
        check("R5 all expected rows delivered", VW'(exp_q.size()), VW'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule